// File: doc/BRIEF.md
# Interleaved Operand SRAM Address Mapper with Result Readback

The block converts logical operand positions into physical addresses of an engine scratch SRAM. That SRAM does not keep the exponent, the modulus and the data operand in three separate areas. It stores them in repeating groups of twelve 32-bit words: four exponent words, then four modulus words, then four data words. A combinational mapping port takes an operand kind and an index and returns both the dword address and the byte address. A second combinational port supports loading a big-endian input byte string in reverse order. For each logical data byte it gives the source position to copy from, or it reports that the byte must be zero-filled.

A readback sequencer reads the result, which sits in the data region. On a start pulse it scans the logical data bytes from the top byte downward and counts away the leading zero bytes. It checks the remaining length against a destination capacity. When the result fits, it streams the bytes out most significant first over a valid/ready handshake. When the result is too long, it reports an error and streams nothing. It issues SRAM reads itself and expects read data one cycle after each read.

Top module: `opmap_sram`

## Requirements
- R1: Exponent kind (map_kind=0) with word index i in 0..511: dword address = (i/4)*12 + i%4, byte address = dword address*4.
- R2: Modulus kind (map_kind=1) with word index i: dword address = (i/4)*12 + i%4 + 4, byte address = dword address*4.
- R3: Data kind (map_kind=2) with logical byte j in 0..2047: dword address = (w/4)*12 + w%4 + 8 with w=j/4, byte address = dword address*4 + j%4. Logical byte 0 is the least significant byte of the operand. The sequencer reads only data-region addresses.
- R4: map_bad is 1 for map_kind=3, or for kinds 0 and 1 with index 512 or more. While map_bad is 1, both address outputs are 0.
- R5: Load port: for input length L and logical byte b, ld_fill=0 and ld_srcpos=L-1-b when b<L. When b>=L, ld_fill=1 and ld_srcpos=0. ld_baddr is the R3 byte address of b.
- R6: After rb_start, the logical data bytes are scanned from 2047 downward. The count starts at 2048 and loses one for each leading zero byte. The bytes from the first nonzero byte down to byte 0 are emitted in that order, including inner zero bytes. rb_done then pulses for one cycle with rb_count equal to the count.
- R7: If the count exceeds rb_cap, rb_done pulses with rb_err=1 and rb_count equal to the count, and no byte is emitted. A count equal to rb_cap is emitted normally.
- R8: An all-zero result ends with rb_count=0, rb_err=0 and no emitted bytes.
- R9: While out_valid=1 and out_ready=0, out_valid stays 1 and out_data does not change.
- R10: rb_start is ignored while rb_busy=1.
- R11: After reset, rb_busy, out_valid, rd_en and rb_done are 0 and rb_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_kind | input | 2 | 0 exponent, 1 modulus, 2 data, 3 invalid |
| map_idx | input | 11 | Word index (kinds 0, 1) or logical byte (kind 2) |
| map_waddr | output | 11 | Physical dword address |
| map_baddr | output | 13 | Physical byte address |
| map_bad | output | 1 | Index or kind out of range |
| ld_len | input | 12 | Input byte string length |
| ld_lbyte | input | 11 | Logical data byte being filled |
| ld_baddr | output | 13 | Physical byte address of ld_lbyte |
| ld_srcpos | output | 11 | Source byte position within the input string |
| ld_fill | output | 1 | Byte lies beyond the input and is zero-filled |
| rb_start | input | 1 | Start a readback |
| rb_cap | input | 12 | Destination capacity in bytes |
| rd_en | output | 1 | SRAM read strobe |
| rd_addr | output | 13 | SRAM byte read address |
| rd_data | input | 8 | SRAM read byte, one cycle after rd_en |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts byte |
| out_data | output | 8 | Output byte |
| rb_busy | output | 1 | Readback in progress |
| rb_done | output | 1 | One-cycle completion pulse |
| rb_count | output | 12 | Result byte count |
| rb_err | output | 1 | Result longer than capacity |

## Verification
The mapping and load outputs are combinational. The bench applies each vector and samples them one time unit later in the same cycle. Readback results appear only after the scan, which costs two cycles per skipped byte, followed by three cycles per emitted byte plus any stall cycles. The bench therefore drives inputs and samples outputs at falling edges, and it waits for the one-cycle rb_done pulse instead of counting a fixed delay. Emitted bytes are collected at each falling edge where valid and ready are both high, the cycle before the transfer edge, and are compared with the byte expected at that position.

// File: rtl/opmap_sram.sv
module opmap_sram #(
  parameter int REGION_WORDS = 512,
  parameter int GRP          = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [1:0]                             map_kind,
  input  logic [$clog2(REGION_WORDS*4)-1:0]      map_idx,
  output logic [$clog2(REGION_WORDS*3)-1:0]      map_waddr,
  output logic [$clog2(REGION_WORDS*3)+1:0]      map_baddr,
  output logic                                   map_bad,
  input  logic [$clog2(REGION_WORDS*4+1)-1:0]    ld_len,
  input  logic [$clog2(REGION_WORDS*4)-1:0]      ld_lbyte,
  output logic [$clog2(REGION_WORDS*3)+1:0]      ld_baddr,
  output logic [$clog2(REGION_WORDS*4)-1:0]      ld_srcpos,
  output logic                                   ld_fill,
  input  logic                                   rb_start,
  input  logic [$clog2(REGION_WORDS*4+1)-1:0]    rb_cap,
  output logic                                   rd_en,
  output logic [$clog2(REGION_WORDS*3)+1:0]      rd_addr,
  input  logic [7:0]                             rd_data,
  output logic                                   out_valid,
  input  logic                                   out_ready,
  output logic [7:0]                             out_data,
  output logic                                   rb_busy,
  output logic                                   rb_done,
  output logic [$clog2(REGION_WORDS*4+1)-1:0]    rb_count,
  output logic                                   rb_err
);
  localparam int BYTES  = REGION_WORDS * 4;
  localparam int BIDXW  = $clog2(BYTES);
  localparam int IDXW   = $clog2(REGION_WORDS);
  localparam int WADDRW = $clog2(REGION_WORDS * 3);
  localparam int BADDRW = WADDRW + 2;
  localparam int CNTW   = $clog2(BYTES + 1);
  localparam int STRIDE = 3 * GRP;

  function automatic logic [WADDRW-1:0] base_of(input logic [IDXW-1:0] i);
    int unsigned u;
    u = int'(i);
    return WADDRW'((u / GRP) * STRIDE + (u % GRP));
  endfunction

  function automatic logic [BADDRW-1:0] dbyte_addr(input logic [BIDXW-1:0] j);
    return {base_of(j[BIDXW-1:2]) + WADDRW'(2 * GRP), j[1:0]};
  endfunction

  // mapping port
  logic [IDXW-1:0]   map_word;
  logic [WADDRW-1:0] map_off;
  assign map_word = (map_kind == 2'd2) ? map_idx[BIDXW-1:2] : map_idx[IDXW-1:0];
  assign map_off  = (map_kind == 2'd0) ? WADDRW'(0) :
                    (map_kind == 2'd1) ? WADDRW'(GRP) : WADDRW'(2 * GRP);
  assign map_bad  = (map_kind == 2'd3) ||
                    (map_kind != 2'd2 && map_idx >= BIDXW'(REGION_WORDS));
  assign map_waddr = map_bad ? '0 : base_of(map_word) + map_off;
  assign map_baddr = map_bad ? '0 :
                     {map_waddr, (map_kind == 2'd2) ? map_idx[1:0] : 2'b00};

  // reversed load port
  logic [CNTW-1:0] ld_diff;
  assign ld_fill   = {1'b0, ld_lbyte} >= ld_len;
  assign ld_diff   = ld_len - {1'b0, ld_lbyte} - CNTW'(1);
  assign ld_srcpos = ld_fill ? '0 : ld_diff[BIDXW-1:0];
  assign ld_baddr  = dbyte_addr(ld_lbyte);

  // readback sequencer
  typedef enum logic [2:0] {IDLE, S_RD, S_CHK, E_RD, E_LAT, E_OUT} st_t;
  st_t             st;
  logic [BIDXW-1:0] idx;
  logic [CNTW-1:0]  cnt, cap_q;
  logic [7:0]       odata;
  logic             done_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      idx    <= '0;
      cnt    <= '0;
      cap_q  <= '0;
      odata  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        IDLE: if (rb_start) begin
          st    <= S_RD;
          idx   <= BIDXW'(BYTES - 1);
          cnt   <= CNTW'(BYTES);
          cap_q <= rb_cap;
          err_q <= 1'b0;
        end
        S_RD: st <= S_CHK;
        S_CHK: begin
          if (rd_data != 8'd0) begin
            if (cnt > cap_q) begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
              st     <= IDLE;
            end else begin
              st <= E_RD;
            end
          end else begin
            cnt <= cnt - CNTW'(1);
            if (idx == '0) begin
              done_q <= 1'b1;
              st     <= IDLE;
            end else begin
              idx <= idx - BIDXW'(1);
              st  <= S_RD;
            end
          end
        end
        E_RD:  st <= E_LAT;
        E_LAT: begin
          odata <= rd_data;
          st    <= E_OUT;
        end
        E_OUT: if (out_ready) begin
          if (idx == '0) begin
            done_q <= 1'b1;
            st     <= IDLE;
          end else begin
            idx <= idx - BIDXW'(1);
            st  <= E_RD;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign rd_en     = (st == S_RD) || (st == E_RD);
  assign rd_addr   = dbyte_addr(idx);
  assign out_valid = (st == E_OUT);
  assign out_data  = odata;
  assign rb_busy   = (st != IDLE);
  assign rb_done   = done_q;
  assign rb_count  = cnt;
  assign rb_err    = err_q;

  p_exp_lane_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_bad && map_kind == 2'd0) |-> ((int'(map_waddr) % STRIDE) < GRP));

  p_rd_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (((int'(rd_addr) >> 2) % STRIDE) >= 2 * GRP));

  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rb_done |-> (!rb_busy && !out_valid));

  p_err_no_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !rb_err);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_busy && rb_start && !out_valid) |=> rb_busy);
endmodule

// File: tb/tb_opmap_sram.sv
module tb_opmap_sram;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [1:0]  map_kind;
  logic [10:0] map_idx, map_waddr, ld_lbyte, ld_srcpos;
  logic [12:0] map_baddr, ld_baddr, rd_addr;
  logic        map_bad, ld_fill, rb_start, rd_en, out_valid, out_ready;
  logic        rb_busy, rb_done, rb_err;
  logic [11:0] ld_len, rb_cap, rb_count;
  logic [7:0]  rd_data, out_data;

  opmap_sram dut (
    .clk(clk), .rst_n(rst_n), .map_kind(map_kind), .map_idx(map_idx),
    .map_waddr(map_waddr), .map_baddr(map_baddr), .map_bad(map_bad),
    .ld_len(ld_len), .ld_lbyte(ld_lbyte), .ld_baddr(ld_baddr),
    .ld_srcpos(ld_srcpos), .ld_fill(ld_fill), .rb_start(rb_start),
    .rb_cap(rb_cap), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .rb_busy(rb_busy), .rb_done(rb_done), .rb_count(rb_count), .rb_err(rb_err)
  );

  int tests = 0, fails = 0, cyc = 0;
  int got_n = 0, byte_bad = 0, exp_cnt_now = 0;
  bit stall = 0;

  logic [31:0] mem [0:1535];

  function automatic int phys(int j);
    int w;
    w = j / 4;
    return (((w / 4) * 12 + w % 4 + 8) * 4) + j % 4;
  endfunction

  function automatic logic [7:0] logical(int j);
    int p;
    p = phys(j);
    return 8'(mem[p / 4] >> (8 * (p % 4)));
  endfunction

  task automatic put(int j, logic [7:0] v);
    int p;
    p = phys(j);
    mem[p / 4][8 * (p % 4) +: 8] = v;
  endtask

  task automatic clear_mem();
    for (int k = 0; k < 1536; k++) mem[k] = 32'd0;
  endtask

  always_ff @(posedge clk)
    if (rd_en) rd_data <= 8'(mem[rd_addr[12:2]] >> (8 * rd_addr[1:0]));

  always @(posedge clk) begin
    cyc++;
    out_ready <= stall ? (cyc % 3 != 0) : 1'b1;
    if (cyc > 190000) begin
      tests++; fails++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 190000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) begin
      if (out_data != logical(exp_cnt_now - 1 - got_n)) byte_bad++;
      got_n++;
    end

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // {kind, idx, waddr, baddr, bad}
  localparam logic [37:0] MAPV [9] = '{
    {2'd0, 11'd0,    11'd0,    13'd0,    1'b0},
    {2'd0, 11'd5,    11'd13,   13'd52,   1'b0},
    {2'd1, 11'd3,    11'd7,    13'd28,   1'b0},
    {2'd1, 11'd511,  11'd1531, 13'd6124, 1'b0},
    {2'd2, 11'd0,    11'd8,    13'd32,   1'b0},
    {2'd2, 11'd6,    11'd9,    13'd38,   1'b0},
    {2'd2, 11'd2047, 11'd1535, 13'd6143, 1'b0},
    {2'd0, 11'd512,  11'd0,    13'd0,    1'b1},
    {2'd3, 11'd0,    11'd0,    13'd0,    1'b1}
  };

  task automatic run_rb(int cap, bit stall_en, bit poke, int exp_count,
                        bit exp_err, string tag);
    int t;
    bit poked;
    t = 0; poked = 0;
    @(negedge clk);
    got_n = 0; byte_bad = 0; exp_cnt_now = exp_count; stall = stall_en;
    rb_cap = 12'(cap); rb_start = 1'b1;
    @(negedge clk);
    rb_start = 1'b0;
    while (!rb_done && t < 20000) begin
      if (poke && !poked && out_valid) begin rb_start = 1'b1; poked = 1; end
      else rb_start = 1'b0;
      @(negedge clk);
      t++;
    end
    rb_start = 1'b0;
    chk(rb_done, {tag, " done pulse"}, int'(rb_done), 1);
    chk(rb_count == 12'(exp_count), {tag, " count"}, int'(rb_count), exp_count);
    chk(rb_err == exp_err, {tag, " err"}, int'(rb_err), int'(exp_err));
    chk(got_n == (exp_err ? 0 : exp_count), {tag, " bytes emitted"}, got_n,
        exp_err ? 0 : exp_count);
    chk(byte_bad == 0, {tag, " byte values"}, byte_bad, 0);
    @(negedge clk);
    chk(!rb_busy && !out_valid, {tag, " idle after"}, int'(rb_busy), 0);
  endtask

  initial begin
    rst_n = 1'b0; rb_start = 1'b0; rb_cap = '0; map_kind = '0; map_idx = '0;
    ld_len = '0; ld_lbyte = '0;
    clear_mem();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!rb_busy && !out_valid && !rd_en && !rb_done, "R11 reset flags",
        int'({rb_busy, out_valid, rd_en, rb_done}), 0);
    chk(rb_count == 12'd0, "R11 reset count", int'(rb_count), 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (MAPV[k]) begin
      string tg;
      map_kind = MAPV[k][37:36];
      map_idx  = MAPV[k][35:25];
      #1;
      tg = MAPV[k][0] ? "R4" : (MAPV[k][37:36] == 2'd0) ? "R1" :
           (MAPV[k][37:36] == 2'd1) ? "R2" : "R3";
      chk(map_bad == MAPV[k][0], {tg, " map_bad"}, int'(map_bad), int'(MAPV[k][0]));
      chk(map_waddr == MAPV[k][24:14], {tg, " dword addr"}, int'(map_waddr),
          int'(MAPV[k][24:14]));
      chk(map_baddr == MAPV[k][13:1], {tg, " byte addr"}, int'(map_baddr),
          int'(MAPV[k][13:1]));
    end

    // R5 reversed load
    ld_len = 12'd5; ld_lbyte = 11'd0; #1;
    chk(!ld_fill && ld_srcpos == 11'd4, "R5 len5 b0", int'(ld_srcpos), 4);
    chk(ld_baddr == 13'(phys(0)), "R5 addr b0", int'(ld_baddr), phys(0));
    ld_lbyte = 11'd4; #1;
    chk(!ld_fill && ld_srcpos == 11'd0, "R5 len5 b4", int'(ld_srcpos), 0);
    ld_lbyte = 11'd5; #1;
    chk(ld_fill, "R5 len5 b5 fill", int'(ld_fill), 1);
    ld_len = 12'd0; ld_lbyte = 11'd0; #1;
    chk(ld_fill, "R5 len0 fill", int'(ld_fill), 1);
    ld_len = 12'd2048; ld_lbyte = 11'd2047; #1;
    chk(!ld_fill && ld_srcpos == 11'd0, "R5 full top", int'(ld_srcpos), 0);
    chk(ld_baddr == 13'(phys(2047)), "R5 addr top", int'(ld_baddr), phys(2047));

    // R6 / R9: short result with inner zero, stalled consumer
    clear_mem(); put(2, 8'hA5); put(1, 8'h00); put(0, 8'h3C);
    run_rb(2048, 1, 0, 3, 0, "R6 R9 three bytes");
    // R6 full-length result, capacity equal
    clear_mem(); put(2047, 8'h80);
    run_rb(2048, 0, 0, 2048, 0, "R6 full length");
    // R7 too long
    clear_mem(); put(4, 8'h11); put(0, 8'h22);
    run_rb(4, 0, 0, 5, 1, "R7 over capacity");
    run_rb(5, 0, 0, 5, 0, "R7 exact capacity");
    // R8 all zero
    clear_mem();
    run_rb(16, 0, 0, 0, 0, "R8 all zero");
    // R10 start during emission ignored
    clear_mem(); put(2, 8'h5A); put(1, 8'h01); put(0, 8'hFF);
    run_rb(2048, 1, 1, 3, 0, "R10 start while busy");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule